// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer attached to a simple register bus with an address, write data, write and read strobes, and read data. An up-counter advances on a slow tick enable. The tick can optionally be divided by a power of two first. When the counter wraps past all ones, the block asserts a reset output for a fixed number of system cycles. It then restarts the count from the load register.

Host software keeps the system alive by writing a new value to the trigger register. Each such write reloads the counter. To stop or start the timer, software writes a two-word key sequence to a start/stop register. A lone word, or a wrong second word, has no effect on the run state.

Every writable register is posted. An accepted write is held for a fixed number of system cycles before it takes effect, which models the crossing into the slow domain. While a write is held, the register's status bit is set and further writes to that register are dropped.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the timer runs, the load and count registers hold 0xFFFB0000, the control and trigger registers read 0, every pending bit reads 0, the reset output is low, and the revision register (word offset 0) returns 0x21 in its low byte.
- R2: While running with the prescaler off, the count (word offset 6) increases by exactly one for each cycle in which the tick input is high, and it does not change otherwise.
- R3: The pending register (word offset 5) has bit 0 for control, bit 2 for load, bit 3 for trigger and bit 4 for start/stop. A bit is set for the 4 clock cycles following an accepted write to its register, and that write takes effect at the end of those cycles. A write to a register whose bit is set is dropped.
- R4: Writing a value to the trigger register (word offset 3) that differs from the stored trigger value reloads the count from the load register (word offset 2).
- R5: Writing the trigger value that is already stored changes neither the count nor anything else.
- R6: When a running count at all ones advances, the count reloads from the load register and the reset output goes high for exactly 16 clock cycles.
- R7: Writing 0x0000AAAA and then 0x00005555 to the start/stop register (word offset 4) stops the timer, and the count then ignores ticks.
- R8: Writing 0x0000BBBB and then 0x00004444 to the start/stop register starts the timer. If the word after a first key word is not its partner, the pair is discarded and the run state stays as it was. A lone second key word is also ignored.
- R9: In the control register (word offset 1), bit 5 enables the prescaler and bits 4:2 give a ratio k. The count then advances once per 2^k ticks, counted from the time the control write takes effect. The other bits are stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow tick enable, one cycle per tick |
| addr_i | input | 4 | Register word offset |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational, 0 when rd_i is low |
| wdt_rst_o | output | 1 | Reset request pulse |

## Verification
Reads are combinational, so a register read in the cycle after a write edge shows the pending bit already set. The written value only becomes visible four edges after the write edge, so the bench waits five cycles before it reads the result. A tick acts on the counter at the edge that samples it, and the reset output rises at that same edge. The bench checks the output level right after that edge, again fifteen edges later, and once more at the sixteenth edge, where it must be low. All outputs are sampled on the falling clock edge or two nanoseconds after a rising edge, never on the active edge itself.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int NSLOT  = 4;

  localparam logic [ADDR_W-1:0] A_REV   = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd1;
  localparam logic [ADDR_W-1:0] A_LOAD  = 4'd2;
  localparam logic [ADDR_W-1:0] A_TRIG  = 4'd3;
  localparam logic [ADDR_W-1:0] A_KEY   = 4'd4;
  localparam logic [ADDR_W-1:0] A_PEND  = 4'd5;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd6;

  localparam int S_CTRL = 0;
  localparam int S_LOAD = 1;
  localparam int S_TRIG = 2;
  localparam int S_KEY  = 3;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_003C;
  localparam logic [DATA_W-1:0] KEY_ON_A  = 32'h0000_BBBB;
  localparam logic [DATA_W-1:0] KEY_ON_B  = 32'h0000_4444;
  localparam logic [DATA_W-1:0] KEY_OFF_A = 32'h0000_AAAA;
  localparam logic [DATA_W-1:0] KEY_OFF_B = 32'h0000_5555;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ON, SEQ_OFF} seq_e;

  function automatic logic [ADDR_W-1:0] slot_addr(int s);
    case (s)
      S_CTRL:  return A_CTRL;
      S_LOAD:  return A_LOAD;
      S_TRIG:  return A_TRIG;
      default: return A_KEY;
    endcase
  endfunction
endpackage

// File: rtl/wdt_posted_slot.sv
module wdt_posted_slot #(
  parameter int DW  = 32,
  parameter int DLY = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output logic          apply_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (wr_i && cnt_q == '0) begin
      cnt_q <= CW'(DLY);
      sh_q  <= wdata_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pend_o  = (cnt_q != '0);
  assign apply_o = (cnt_q == CW'(1));
  assign data_o  = sh_q;
endmodule

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               adv_o
);
  localparam int PC_W = (1 << RATIO_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] lim;
  logic            hit;

  assign lim   = (PC_W'(1) << ratio_i) - PC_W'(1);
  assign hit   = (pc_q == lim);
  assign adv_o = tick_i && (!en_i || hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pc_q <= '0;
    else if (clr_i)            pc_q <= '0;
    else if (tick_i && en_i)   pc_q <= hit ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/wdt_arm_seq.sv
module wdt_arm_seq
  import wdt_keyed_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apply_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              armed_o
);
  seq_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SEQ_IDLE;
      armed_o <= 1'b1;
    end else if (apply_i) begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (word_i == KEY_ON_A)       st_q <= SEQ_ON;
          else if (word_i == KEY_OFF_A) st_q <= SEQ_OFF;
        end
        SEQ_ON: begin
          if (word_i == KEY_ON_B) armed_o <= 1'b1;
          st_q <= SEQ_IDLE;
        end
        SEQ_OFF: begin
          if (word_i == KEY_OFF_B) armed_o <= 1'b0;
          st_q <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
  parameter int             CNT_W    = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = 32'hFFFB_0000,
  parameter int             RST_CYC  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic             adv_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_o
);
  localparam int RW = $clog2(RST_CYC + 1);

  logic [RW-1:0] rc_q;
  logic          wrap;

  assign wrap = armed_i && adv_i && !reload_i && (count_o == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                count_o <= LOAD_RST;
    else if (reload_i || wrap)  count_o <= load_i;
    else if (armed_i && adv_i)  count_o <= count_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rc_q <= '0;
    else if (wrap)       rc_q <= RW'(RST_CYC);
    else if (rc_q != '0) rc_q <= rc_q - 1'b1;
  end

  assign rst_o = (rc_q != '0);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int               CNT_W    = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = 32'hFFFB_0000,
  parameter int               PEND_CYC = 4,
  parameter int               RST_CYC  = 16,
  parameter int               RATIO_W  = 3,
  parameter logic [7:0]       REV      = 8'h21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdt_rst_o
);
  logic [NSLOT-1:0]             slot_pend;
  logic [NSLOT-1:0]             slot_apply;
  logic [NSLOT-1:0][DATA_W-1:0] slot_data;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    wdt_posted_slot #(.DW(DATA_W), .DLY(PEND_CYC)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_i && (addr_i == slot_addr(s))),
      .wdata_i (wdata_i),
      .pend_o  (slot_pend[s]),
      .apply_o (slot_apply[s]),
      .data_o  (slot_data[s])
    );
  end

  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [DATA_W-1:0] trig_q;
  logic              trig_reload;

  // reload only on a changed trigger value
  assign trig_reload = slot_apply[S_TRIG] && (slot_data[S_TRIG] != trig_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= LOAD_RST;
      trig_q <= '0;
    end else begin
      if (slot_apply[S_CTRL]) ctrl_q <= slot_data[S_CTRL] & CTRL_MASK;
      if (slot_apply[S_LOAD]) load_q <= slot_data[S_LOAD][CNT_W-1:0];
      if (slot_apply[S_TRIG]) trig_q <= slot_data[S_TRIG];
    end
  end

  logic armed;
  wdt_arm_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .apply_i (slot_apply[S_KEY]),
    .word_i  (slot_data[S_KEY]),
    .armed_o (armed)
  );

  logic adv;
  wdt_tick_div #(.RATIO_W(RATIO_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clr_i   (slot_apply[S_CTRL]),
    .en_i    (ctrl_q[5]),
    .ratio_i (ctrl_q[2 +: RATIO_W]),
    .adv_o   (adv)
  );

  logic [CNT_W-1:0] count;
  wdt_count_core #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST), .RST_CYC(RST_CYC)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .armed_i  (armed),
    .adv_i    (adv),
    .reload_i (trig_reload),
    .load_i   (load_q),
    .count_o  (count),
    .rst_o    (wdt_rst_o)
  );

  logic [DATA_W-1:0] cnt_ext, load_ext, pend_word, rd_mux;

  always_comb begin
    cnt_ext  = '0;
    load_ext = '0;
    cnt_ext[CNT_W-1:0]  = count;
    load_ext[CNT_W-1:0] = load_q;
    pend_word    = '0;
    pend_word[0] = slot_pend[S_CTRL];
    pend_word[2] = slot_pend[S_LOAD];
    pend_word[3] = slot_pend[S_TRIG];
    pend_word[4] = slot_pend[S_KEY];
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_REV:   rd_mux[7:0] = REV;
      A_CTRL:  rd_mux = ctrl_q;
      A_LOAD:  rd_mux = load_ext;
      A_TRIG:  rd_mux = trig_q;
      A_PEND:  rd_mux = pend_word;
      A_COUNT: rd_mux = cnt_ext;
      default: rd_mux = '0;
    endcase
  end

  assign rdata_o = rd_i ? rd_mux : '0;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CNT_W    = 32,
  parameter int PEND_CYC = 4,
  parameter int RST_CYC  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wdt_rst,
  input logic             armed,
  input logic             adv,
  input logic             trig_reload,
  input logic             key_apply,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] load,
  input logic [3:0]       pend
);
  logic [7:0] hi_cnt;
  logic [7:0] age [4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_cnt <= '0;
    else if (wdt_rst) hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  for (genvar i = 0; i < 4; i++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      age[i] <= '0;
      else if (pend[i]) age[i] <= (age[i] == 8'hFF) ? age[i] : age[i] + 1'b1;
      else              age[i] <= '0;
    end
    AST_PEND_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend[i]) |-> age[i] == 8'(PEND_CYC)); // R3
  end

  AST_RST_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst |-> hi_cnt < 8'(RST_CYC)); // R6
  AST_RST_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst) |-> hi_cnt == 8'(RST_CYC)); // R6
  AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && adv && !trig_reload && count == '1) |=> (count == $past(load) && wdt_rst)); // R6
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !trig_reload) |=> $stable(count)); // R7
  AST_ARM_BY_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(armed) |-> $past(key_apply)); // R8
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W), .PEND_CYC(PEND_CYC), .RST_CYC(RST_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wdt_rst     (wdt_rst_o),
  .armed       (armed),
  .adv         (adv),
  .trig_reload (trig_reload),
  .key_apply   (slot_apply[3]),
  .count       (count),
  .load        (load_q),
  .pend        (slot_pend)
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic        wdt_rst;

  always #10 clk = ~clk;

  wdt_keyed u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .wdt_rst_o(wdt_rst)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // monitor: pops the expected item for every read
  always @(negedge clk) begin
    if (rd) begin
      if (q.size() == 0) begin
        total++; fails++;
        $display("FAIL scoreboard: read with empty queue, actual %h expected none", rdata);
      end else begin
        item_t it;
        it = q.pop_front();
        total++;
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #2;
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #2;
    wr = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    addr = a; rd = 1'b1;
    @(negedge clk); #1;
    rd = 1'b0;
    @(posedge clk); #2;
  endtask

  task automatic pin_chk(logic e, string tag);
    total++;
    if (wdt_rst !== e) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, wdt_rst, e);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; tick = 1'b1;
      @(posedge clk); #2; tick = 1'b0;
    end
  endtask

  task automatic wr_wait(logic [3:0] a, logic [31:0] d);
    wr_reg(a, d);
    cyc(5);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    cyc(3);
    @(negedge clk); rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    rd_chk(4'd0, 32'h0000_0021, "R1 revision");
    rd_chk(4'd1, 32'h0, "R1 ctrl");
    rd_chk(4'd2, 32'hFFFB_0000, "R1 load");
    rd_chk(4'd3, 32'h0, "R1 trigger");
    rd_chk(4'd5, 32'h0, "R1 pending");
    rd_chk(4'd6, 32'hFFFB_0000, "R1 count");
    pin_chk(1'b0, "R1 reset pin");

    // R2 counting
    ticks(3);
    rd_chk(4'd6, 32'hFFFB_0003, "R2 count after 3 ticks");
    cyc(4);
    rd_chk(4'd6, 32'hFFFB_0003, "R2 count idle without tick");

    // R3 pending and drop
    wr_reg(4'd2, 32'hFFFF_FFF0);
    rd_chk(4'd5, 32'h0000_0004, "R3 load pending bit");
    wr_reg(4'd2, 32'h1234_5678);
    cyc(5);
    rd_chk(4'd2, 32'hFFFF_FFF0, "R3 write during pending dropped");
    rd_chk(4'd5, 32'h0, "R3 pending cleared");
    rd_chk(4'd6, 32'hFFFB_0003, "R3 load write does not reload");

    // R4 trigger reload
    wr_reg(4'd3, 32'h1);
    rd_chk(4'd5, 32'h0000_0008, "R4 trigger pending bit");
    cyc(5);
    rd_chk(4'd6, 32'hFFFF_FFF0, "R4 reload on trigger");

    // R5 same trigger value
    ticks(2);
    wr_wait(4'd3, 32'h1);
    rd_chk(4'd6, 32'hFFFF_FFF2, "R5 same trigger ignored");
    wr_wait(4'd3, 32'h2);
    rd_chk(4'd6, 32'hFFFF_FFF0, "R4 new trigger reloads");

    // R6 overflow
    ticks(15);
    rd_chk(4'd6, 32'hFFFF_FFFF, "R6 count at all ones");
    pin_chk(1'b0, "R6 pin low before wrap");
    ticks(1);
    pin_chk(1'b1, "R6 pin high at wrap");
    cyc(15);
    pin_chk(1'b1, "R6 pin high cycle 16");
    cyc(1);
    pin_chk(1'b0, "R6 pin low after 16");
    rd_chk(4'd6, 32'hFFFF_FFF0, "R6 reload from load on wrap");

    // R7 stop sequence
    wr_reg(4'd4, 32'h0000_AAAA);
    rd_chk(4'd5, 32'h0000_0010, "R3 key pending bit");
    cyc(5);
    wr_wait(4'd4, 32'h0000_5555);
    ticks(4);
    rd_chk(4'd6, 32'hFFFF_FFF0, "R7 stopped ignores ticks");

    // R8 bad and good start sequences
    wr_wait(4'd4, 32'h0000_BBBB);
    wr_wait(4'd4, 32'h0000_1234);
    wr_wait(4'd4, 32'h0000_4444);
    ticks(2);
    rd_chk(4'd6, 32'hFFFF_FFF0, "R8 wrong partner discarded");
    wr_wait(4'd4, 32'h0000_BBBB);
    wr_wait(4'd4, 32'h0000_4444);
    ticks(2);
    rd_chk(4'd6, 32'hFFFF_FFF2, "R8 start sequence runs");
    wr_wait(4'd4, 32'h0000_AAAA);
    wr_wait(4'd4, 32'h0000_4444);
    ticks(1);
    rd_chk(4'd6, 32'hFFFF_FFF3, "R8 bad stop pair keeps running");

    // R9 prescaler divide by 4
    wr_reg(4'd1, 32'h0000_00A8);
    rd_chk(4'd5, 32'h0000_0001, "R3 ctrl pending bit");
    cyc(5);
    rd_chk(4'd1, 32'h0000_0028, "R9 ctrl stored masked");
    wr_wait(4'd3, 32'h3);
    ticks(3);
    rd_chk(4'd6, 32'hFFFF_FFF0, "R9 no advance before 4 ticks");
    ticks(1);
    rd_chk(4'd6, 32'hFFFF_FFF1, "R9 advance on 4th tick");
    ticks(4);
    rd_chk(4'd6, 32'hFFFF_FFF2, "R9 second divided step");

    cyc(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule